// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Bus Arbitration

This engine copies a block of words between one peripheral and memory so that the processor does not have to. Software first sets up three registers over a small slave port: the starting memory address, the number of words to move, and a control word. The control word picks the direction, picks the arbitration policy, and starts the engine. A chip-select qualifies each access, a two-bit register select picks the register, and separate read and write strobes say what kind of access it is.

Once started, the engine asks the processor for the system bus and waits for the grant. While it owns the bus, it services peripheral requests one word at a time. For each word it acknowledges the peripheral, puts the current memory address on the bus, and pulses the memory read or write strobe. The address then moves up by one and the remaining count goes down by one. When the count runs out, the engine gives up the bus and raises an interrupt that stays up until software writes the control register.

There are two arbitration policies. In burst policy the bus is held for the whole block. In cycle-stealing policy the bus is requested only when the peripheral asks for a word, and it is released after every word.

Top module: `dma_engine`

## Requirements
- R1: After synchronous reset, bus_req, dev_ack, mem_rd, mem_wr and irq are low, and the address, count and control registers all read back as zero.
- R2: With cs and wr high at a clock edge and the engine idle, din is written to the register picked by rs: 0 is the address, 1 is the word count, 2 is control. In control, bit 0 is the direction (1 means peripheral to memory and uses mem_wr; 0 means memory to peripheral and uses mem_rd), bit 1 is the policy (1 is cycle stealing, 0 is burst) and bit 2 is start, which is not stored. While cs and rd are high, dout shows the picked register without waiting for a clock. A control read also returns busy in bit 3 and irq in bit 4. Otherwise dout is zero.
- R3: dev_ack, mem_rd and mem_wr are asserted only while both bus_req and bus_grant are high. mem_addr is zero whenever the engine does not own the bus.
- R4: A word moves in each cycle of an active transfer in which bus_grant and dev_req are both high. In that cycle dev_ack and exactly one strobe, chosen by the direction, are high, and mem_addr carries the current address. Afterwards the address goes up by one, wrapping at its width, and the count goes down by one.
- R5: In burst policy, bus_req stays high without a break from the moment it is first raised until the last word of the block.
- R6: In cycle-stealing policy, bus_req is low whenever dev_req is low, and it drops for at least one cycle between two consecutive words.
- R7: In the cycle after the last word, bus_req is low and irq is high. irq then stays high until a control-register write.
- R8: While a transfer is active, register writes through the slave port are ignored.
- R9: A count read during a transfer returns the live number of words left, which is zero after the block completes.
- R10: A start written while the count register is zero does not begin a transfer: bus_req stays low and busy reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Slave port select |
| rs | input | 2 | Register select (0 address, 1 count, 2 control) |
| rd | input | 1 | Slave read strobe |
| wr | input | 1 | Slave write strobe |
| din | input | DW | Slave write data |
| dout | output | DW | Slave read data |
| dev_req | input | 1 | Peripheral asks for one word to be serviced |
| dev_ack | output | 1 | Peripheral word is being serviced this cycle |
| bus_req | output | 1 | Request for the system bus |
| bus_grant | input | 1 | Processor has released the system bus |
| mem_addr | output | AW | Memory address while the bus is owned |
| mem_rd | output | 1 | Memory read strobe (memory to peripheral) |
| mem_wr | output | 1 | Memory write strobe (peripheral to memory) |
| irq | output | 1 | Block-complete interrupt |

## Verification
The hardest situation to reach is the interplay of a slow grant with a peripheral that pauses between words. That interplay is what shows whether the engine releases the bus between stolen cycles and whether it keeps the bus through a stalled burst. The stimulus sweeps both policies, both directions, block lengths from one to four, grant latencies from zero to two cycles and peripheral pauses from zero to two cycles. One of the blocks starts near the top of the address space so that the address wraps. A separate run holds the peripheral quiet after start and tries to overwrite every register while the engine is busy.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_XFER = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_t;

    localparam int CTRL_DIR_BIT   = 0;
    localparam int CTRL_MODE_BIT  = 1;
    localparam int CTRL_START_BIT = 2;
    localparam int STAT_BUSY_BIT  = 3;
    localparam int STAT_IRQ_BIT   = 4;

    typedef struct packed {
        logic to_mem;
        logic steal;
    } xfer_cfg_t;

    function automatic xfer_cfg_t decode_cfg(input logic dir_bit, input logic mode_bit);
        xfer_cfg_t c;
        c.to_mem = dir_bit;
        c.steal  = mode_bit;
        return c;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dmac_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic [1:0]    rs,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] din,
    input  logic          busy,
    input  logic          step,
    input  logic          irq_set,
    output logic [DW-1:0] dout,
    output logic [AW-1:0] addr,
    output xfer_cfg_t     cfg,
    output logic          start,
    output logic          last,
    output logic          irq
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    xfer_cfg_t     cfg_q;
    logic          irq_q;
    logic          wr_ok;
    reg_sel_t      sel;

    assign sel   = reg_sel_t'(rs);
    assign wr_ok = cs && wr && !busy;
    assign start = wr_ok && (sel == SEL_CTRL) && din[CTRL_START_BIT] && (cnt_q != '0);
    assign last  = (cnt_q == CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            cfg_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_ok && sel == SEL_ADDR)
                addr_q <= AW'(din);
            else if (step)
                addr_q <= addr_q + AW'(1);

            if (wr_ok && sel == SEL_COUNT)
                cnt_q <= CW'(din);
            else if (step)
                cnt_q <= cnt_q - CNT_ONE;

            if (wr_ok && sel == SEL_CTRL)
                cfg_q <= decode_cfg(din[CTRL_DIR_BIT], din[CTRL_MODE_BIT]);

            if (irq_set)
                irq_q <= 1'b1;
            else if (wr_ok && sel == SEL_CTRL)
                irq_q <= 1'b0;
        end
    end

    always_comb begin
        dout = '0;
        if (cs && rd) begin
            case (sel)
                SEL_ADDR:  dout = DW'(addr_q);
                SEL_COUNT: dout = DW'(cnt_q);
                SEL_CTRL: begin
                    dout[CTRL_DIR_BIT]  = cfg_q.to_mem;
                    dout[CTRL_MODE_BIT] = cfg_q.steal;
                    dout[STAT_BUSY_BIT] = busy;
                    dout[STAT_IRQ_BIT]  = irq_q;
                end
                default:   dout = '0;
            endcase
        end
    end

    assign addr = addr_q;
    assign cfg  = cfg_q;
    assign irq  = irq_q;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic steal,
    input  logic last,
    input  logic dev_req,
    input  logic bus_grant,
    output logic bus_req,
    output logic own,
    output logic word,
    output logic done,
    output logic busy
);

    seq_state_t state_q, state_d;

    assign bus_req = (state_q == ST_XFER);
    assign own     = bus_req && bus_grant;
    assign word    = own && dev_req;
    assign done    = word && last;
    assign busy    = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_ARM;
            ST_ARM:  if (!steal || dev_req) state_d = ST_XFER;
            ST_XFER: begin
                if (word) begin
                    if (last)
                        state_d = ST_IDLE;
                    else if (steal)
                        state_d = ST_ARM;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/dma_busif.sv
module dma_busif #(
    parameter int AW = 8
) (
    input  logic          own,
    input  logic          word,
    input  logic          to_mem,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          dev_ack
);

    assign mem_addr = own ? addr : '0;
    assign dev_ack  = word;
    assign mem_wr   = word && to_mem;
    assign mem_rd   = word && !to_mem;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dmac_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic [1:0]    rs,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic          dev_req,
    output logic          dev_ack,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          irq
);

    logic          busy, step, done, start, last, own;
    logic [AW-1:0] cur_addr;
    xfer_cfg_t     cfg;

    dma_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .cs(cs), .rs(rs), .rd(rd), .wr(wr), .din(din),
        .busy(busy), .step(step), .irq_set(done),
        .dout(dout), .addr(cur_addr), .cfg(cfg), .start(start), .last(last), .irq(irq)
    );

    dma_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .steal(cfg.steal), .last(last),
        .dev_req(dev_req), .bus_grant(bus_grant),
        .bus_req(bus_req), .own(own), .word(step), .done(done), .busy(busy)
    );

    dma_busif #(.AW(AW)) u_bus (
        .own(own), .word(step), .to_mem(cfg.to_mem), .addr(cur_addr),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .dev_ack(dev_ack)
    );

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cs,
    input logic [1:0]    rs,
    input logic          wr,
    input logic          dev_req,
    input logic          dev_ack,
    input logic          bus_req,
    input logic          bus_grant,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          irq
);

    // R3: no bus activity without ownership
    assert_strobe_needs_grant_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr || dev_ack) |-> (bus_req && bus_grant));

    // R3: address lines quiet when not owning the bus
    assert_addr_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && bus_grant) |-> (mem_addr == '0));

    // R4: never both strobes
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    // R4: acknowledge only answers a pending request
    assert_ack_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
        dev_ack |-> dev_req);

    // R7: interrupt held until a control write
    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (irq && !(cs && wr && rs == 2'd2)) |=> irq);

    // R7: bus released when the interrupt appears
    assert_irq_bus_free_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !bus_req);

endmodule

bind dma_engine dma_engine_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .cs(cs), .rs(rs), .wr(wr),
    .dev_req(dev_req), .dev_ack(dev_ack), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq)
);

// File: tb/tb_dma_engine.sv
module tb_dma_engine;

    localparam int DW = 8;
    localparam int AW = 8;
    localparam int CW = 8;
    localparam int HALF = 10; // 20 ns period, 50 MHz
    localparam int AMASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0]    rs = 2'd0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dev_req = 1'b0;
    logic          dev_ack, bus_req, bus_grant, mem_rd, mem_wr, irq;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int req_cnt = 0;

    dma_engine #(.DW(DW), .AW(AW), .CW(CW)) dut (
        .clk(clk), .rst(rst), .cs(cs), .rs(rs), .rd(rd), .wr(wr), .din(din),
        .dout(dout), .dev_req(dev_req), .dev_ack(dev_ack), .bus_req(bus_req),
        .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .irq(irq)
    );

    always #HALF clk = ~clk;

    // processor-side arbiter: grants after lat cycles of continuous request
    always @(posedge clk) req_cnt <= bus_req ? req_cnt + 1 : 0;
    assign bus_grant = bus_req && (req_cnt >= lat);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input int sel, input int val);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; rd = 1'b0; rs = 2'(sel); din = DW'(val);
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic reg_read(input int sel, output int val);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; wr = 1'b0; rs = 2'(sel);
        #1 val = int'(dout);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic run_xfer(input int a, input int n, input bit to_mem, input bit steal, input int gap);
        int k = 0, gapc = 0, v;
        bit saw_low = 1'b1, burst_ok = 1'b1, steal_ok = 1'b1, started = 1'b0;
        reg_write(0, a);
        reg_write(1, n);
        reg_write(2, 4 | (int'(steal) << 1) | int'(to_mem));
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; rs = 2'd1;
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (cyc != 0) @(negedge clk);
            dev_req = (gapc == 0);
            #1;
            if (bus_req) started = 1'b1;
            if (steal && !dev_req && bus_req) steal_ok = 1'b0;
            if (!steal && started && !bus_req) burst_ok = 1'b0;
            if (!bus_req) saw_low = 1'b1;
            if (dev_ack) begin
                check(int'(mem_addr) == ((a + k) & AMASK), "R4 address", int'(mem_addr), (a + k) & AMASK);
                check({mem_wr, mem_rd} == (to_mem ? 2'b10 : 2'b01), "R4 strobe",
                      int'({mem_wr, mem_rd}), to_mem ? 2 : 1);
                check(int'(dout) == n - k, "R9 live count", int'(dout), n - k);
                if (steal && k > 0) check(saw_low, "R6 bus released between words", 0, 1);
                saw_low = 1'b0;
                k++;
                gapc = gap;
                if (k == n) break;
            end else if (gapc > 0) begin
                gapc--;
            end
        end
        check(k == n, "R4 word total", k, n);
        if (steal) check(steal_ok, "R6 no request while peripheral idle", 0, 1);
        else       check(burst_ok, "R5 bus held through block", 0, 1);
        @(negedge clk);
        dev_req = 1'b0;
        #1;
        check(!bus_req, "R7 bus dropped after last word", int'(bus_req), 0);
        check(irq, "R7 irq raised", int'(irq), 1);
        check(int'(dout) == 0, "R9 count zero at end", int'(dout), 0);
        cs = 1'b0; rd = 1'b0;
        reg_read(0, v);
        check(v == ((a + n) & AMASK), "R4 final address", v, (a + n) & AMASK);
        repeat (3) @(negedge clk);
        reg_read(2, v);
        check(v == (16 | (int'(steal) << 1) | int'(to_mem)), "R7 R2 status after completion",
              v, 16 | (int'(steal) << 1) | int'(to_mem));
        reg_write(2, 0);
        #1;
        check(!irq, "R7 irq cleared by control write", int'(irq), 0);
    endtask

    initial begin
        #(2 * HALF * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, acks;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check({bus_req, dev_ack, mem_rd, mem_wr, irq} == 5'b0, "R1 outputs after reset",
              int'({bus_req, dev_ack, mem_rd, mem_wr, irq}), 0);
        reg_read(0, v); check(v == 0, "R1 address reset", v, 0);
        reg_read(1, v); check(v == 0, "R1 count reset", v, 0);
        reg_read(2, v); check(v == 0, "R1 control reset", v, 0);

        // R2: register readback, no start
        reg_write(0, 8'h5A);
        reg_write(1, 8'h21);
        reg_write(2, 8'h03);
        reg_read(0, v); check(v == 8'h5A, "R2 address readback", v, 8'h5A);
        reg_read(1, v); check(v == 8'h21, "R2 count readback", v, 8'h21);
        reg_read(2, v); check(v == 8'h03, "R2 control readback", v, 8'h03);
        @(negedge clk); #1;
        check(int'(dout) == 0, "R2 dout zero without read", int'(dout), 0);

        // R10: start with zero count
        reg_write(1, 0);
        reg_write(2, 4);
        acks = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            if (bus_req) acks++;
        end
        check(acks == 0, "R10 no bus request", acks, 0);
        reg_read(2, v); check(v == 0, "R10 busy clear", v, 0);

        // R4 R5 R6 R7 R9: sweep
        for (int steal = 0; steal < 2; steal++)
            for (int dir = 0; dir < 2; dir++)
                for (int n = 1; n <= 4; n++)
                    for (int gap = 0; gap < 3; gap++)
                        for (int l = 0; l < 3; l++) begin
                            lat = l;
                            run_xfer((n == 4) ? 254 : 16 * n + gap, n, bit'(dir), bit'(steal), gap);
                        end

        // R8: writes ignored while busy
        lat = 1;
        dev_req = 1'b0;
        reg_write(0, 8'h40);
        reg_write(1, 3);
        reg_write(2, 4);
        repeat (3) @(negedge clk);
        reg_write(0, 8'h99);
        reg_write(1, 7);
        reg_write(2, 8'h03);
        reg_read(0, v); check(v == 8'h40, "R8 address kept", v, 8'h40);
        reg_read(1, v); check(v == 3, "R8 count kept", v, 3);
        reg_read(2, v); check(v == 8, "R8 control kept, busy set", v, 8);
        acks = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            dev_req = 1'b1;
            #1;
            if (dev_ack) begin
                check(int'(mem_addr) == 8'h40 + acks, "R8 transfer uses original address",
                      int'(mem_addr), 8'h40 + acks);
                acks++;
            end
        end
        dev_req = 1'b0;
        check(acks == 3, "R8 original count used", acks, 3);
        reg_read(0, v); check(v == 8'h43, "R8 final address", v, 8'h43);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule